// File: doc/BRIEF.md
# Context-Switch Acknowledge Watchdog

This block watches every engine in a group and times how long each engine takes to acknowledge a context-switch request. A shared configuration register holds a timeout period and a detection-enable bit. Each engine has its own down-counter. The counter loads the period when a request is issued. It stops when the engine acknowledges the request or is reset. If the counter runs out first, the block sets that engine's sticky pending bit.

When the pending bit is set, the block freezes a snapshot of three values from that engine: the switch phase and the outgoing and incoming context group IDs. From then on it tracks a live four-state status that tells software what happened to the late request. Software clears pending bits by writing ones to them. Clearing a bit also empties that engine's snapshot and status, so the next timeout captures a fresh record.

Top module: `ctxsw_watchdog`

## Requirements
- R1: With detection enabled and period P, a request sampled at clock edge 0 times out only if no acknowledge is sampled at edges 1 to P+1. A timeout sets the engine's pending bit at edge P+1.
- R2: While the detection-enable bit is 0, no pending bit is ever set, however long a request stays unacknowledged.
- R3: A cycle with `clr_we` high clears every pending bit whose `clr_mask` bit is 1 and leaves all other pending bits unchanged. A mask of all ones clears every engine. A cleared engine reads 0 in its status, phase and ID fields.
- R4: At a timeout, the engine's phase input (2 bits: 0 load, 1 switch, 2 save) and its previous and next ID inputs are captured. While the pending bit stays set, these captured values do not change.
- R5: The 2-bit status field is encoded as 0 awaiting ack, 1 engine was reset, 2 ack received and 3 dropped timeout. It reads 0 at the cycle the pending bit is set.
- R6: A late acknowledge of the timed-out request moves the status from 0 to 2 at the edge where the acknowledge is sampled.
- R7: An engine reset while the status is 0 moves it to 1. A later acknowledge of the timed-out request, with no new request issued in between, then moves it to 2.
- R8: If a further request times out while the pending bit is set and the status is 1 or 2, the status becomes 3. The status stays at 3 until it is cleared, and the snapshot is not replaced.
- R9: A timeout captured in the save phase keeps reporting phase 2 after its late acknowledge sets the status to 2, even though the phase input has moved on to load.
- R10: A new request reloads the counter from the period, so the time limit is measured from the latest request. An engine reset stops the count, and no timeout follows.
- R11: If a clear and a new timeout reach the same engine in the same cycle, the timeout wins. The pending bit stays set, the status reads 0 and the snapshot holds the new inputs.
- R12: Engines are independent. A timeout, acknowledge or clear on one engine leaves every other engine's pending bit and fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_period | input | PERIOD_W | Timeout period to load |
| cfg_detect_en | input | 1 | Detection enable to load |
| clr_we | input | 1 | Write strobe for the pending register (write one to clear) |
| clr_mask | input | NUM_ENG | One bit per engine; a 1 clears that engine |
| eng_req | input | NUM_ENG | Context-switch request pulse per engine |
| eng_ack | input | NUM_ENG | Acknowledge pulse per engine |
| eng_rst | input | NUM_ENG | Engine reset pulse per engine |
| eng_phase | input | 2*NUM_ENG | Current switch phase per engine |
| eng_prev_id | input | ID_W*NUM_ENG | Outgoing context group ID per engine |
| eng_next_id | input | ID_W*NUM_ENG | Incoming context group ID per engine |
| pending | output | NUM_ENG | Sticky timeout pending bits |
| info_phase | output | 2*NUM_ENG | Captured phase per engine |
| info_prev_id | output | ID_W*NUM_ENG | Captured outgoing ID per engine |
| info_next_id | output | ID_W*NUM_ENG | Captured incoming ID per engine |
| info_status | output | 2*NUM_ENG | Live status per engine |

## Verification
The bench builds the block with two engines, a 4-bit period and 3-bit IDs. With a 4-bit period, a sweep can cover every period from 0 to 5 against every acknowledge delay up to three cycles past the limit. That places the acknowledge on both sides of the edge-P+1 boundary for each period. With two engines, the bench can check partial and full clear masks and show that engines are independent. With 3-bit IDs, each sweep point can carry its own snapshot pattern, so a frozen capture can be told apart from a live input.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
  // Live status of a pending timeout record
  typedef enum logic [1:0] {
    ST_AWAIT   = 2'd0,
    ST_ENG_RST = 2'd1,
    ST_ACKED   = 2'd2,
    ST_DROPPED = 2'd3
  } wd_status_e;
endpackage

// File: rtl/ctxsw_timer.sv
module ctxsw_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                det_en_i,
  input  logic                req_i,
  input  logic                ack_i,
  input  logic                eng_rst_i,
  output logic                fire_o,
  output logic                late_ack_o
);
  logic                busy_q;
  logic                expired_q;
  logic [PERIOD_W-1:0] cnt_q;

  // One timeout per request; an acknowledge, reset or new request in the
  // same cycle suppresses it.
  assign fire_o = busy_q && !expired_q && (cnt_q == '0) && det_en_i &&
                  !ack_i && !eng_rst_i && !req_i;
  assign late_ack_o = ack_i && expired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      expired_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (eng_rst_i)                  busy_q <= 1'b0;
      else if (ack_i)                 busy_q <= 1'b0;
      else if (req_i) begin
        busy_q <= 1'b1;
        cnt_q  <= period_i;
      end else if (busy_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;

      // The timed-out request stays expected until acked or superseded,
      // even across an engine reset.
      if (ack_i || req_i) expired_q <= 1'b0;
      else if (fire_o)    expired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ctxsw_info.sv
module ctxsw_info
  import ctxsw_pkg::*;
#(
  parameter int ID_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire_i,
  input  logic            late_ack_i,
  input  logic            eng_rst_i,
  input  logic            clr_i,
  input  logic [1:0]      phase_i,
  input  logic [ID_W-1:0] prev_i,
  input  logic [ID_W-1:0] next_i,
  output logic            pend_o,
  output logic [1:0]      phase_o,
  output logic [ID_W-1:0] prev_o,
  output logic [ID_W-1:0] next_o,
  output logic [1:0]      status_o
);
  wd_status_e st_q;

  assign status_o = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o  <= 1'b0;
      phase_o <= '0;
      prev_o  <= '0;
      next_o  <= '0;
      st_q    <= ST_AWAIT;
    end else if (fire_i && (!pend_o || clr_i)) begin
      // fresh record; wins over a simultaneous clear
      pend_o  <= 1'b1;
      phase_o <= phase_i;
      prev_o  <= prev_i;
      next_o  <= next_i;
      st_q    <= ST_AWAIT;
    end else if (clr_i) begin
      pend_o  <= 1'b0;
      phase_o <= '0;
      prev_o  <= '0;
      next_o  <= '0;
      st_q    <= ST_AWAIT;
    end else if (pend_o) begin
      if (fire_i)
        st_q <= ST_DROPPED;
      else if (late_ack_i && (st_q == ST_AWAIT || st_q == ST_ENG_RST))
        st_q <= ST_ACKED;
      else if (eng_rst_i && st_q == ST_AWAIT)
        st_q <= ST_ENG_RST;
    end
  end
endmodule

// File: rtl/ctxsw_watchdog.sv
module ctxsw_watchdog #(
  parameter int NUM_ENG  = 8,
  parameter int PERIOD_W = 16,
  parameter int ID_W     = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [PERIOD_W-1:0]     cfg_period,
  input  logic                    cfg_detect_en,
  input  logic                    clr_we,
  input  logic [NUM_ENG-1:0]      clr_mask,
  input  logic [NUM_ENG-1:0]      eng_req,
  input  logic [NUM_ENG-1:0]      eng_ack,
  input  logic [NUM_ENG-1:0]      eng_rst,
  input  logic [2*NUM_ENG-1:0]    eng_phase,
  input  logic [ID_W*NUM_ENG-1:0] eng_prev_id,
  input  logic [ID_W*NUM_ENG-1:0] eng_next_id,
  output logic [NUM_ENG-1:0]      pending,
  output logic [2*NUM_ENG-1:0]    info_phase,
  output logic [ID_W*NUM_ENG-1:0] info_prev_id,
  output logic [ID_W*NUM_ENG-1:0] info_next_id,
  output logic [2*NUM_ENG-1:0]    info_status
);
  logic [PERIOD_W-1:0] period_q;
  logic                det_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '1;
      det_en_q <= 1'b0;
    end else if (cfg_we) begin
      period_q <= cfg_period;
      det_en_q <= cfg_detect_en;
    end
  end

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    logic fire, late_ack;

    ctxsw_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .period_i  (period_q),
      .det_en_i  (det_en_q),
      .req_i     (eng_req[e]),
      .ack_i     (eng_ack[e]),
      .eng_rst_i (eng_rst[e]),
      .fire_o    (fire),
      .late_ack_o(late_ack)
    );

    ctxsw_info #(.ID_W(ID_W)) u_info (
      .clk       (clk),
      .rst       (rst),
      .fire_i    (fire),
      .late_ack_i(late_ack),
      .eng_rst_i (eng_rst[e]),
      .clr_i     (clr_we && clr_mask[e]),
      .phase_i   (eng_phase[2*e +: 2]),
      .prev_i    (eng_prev_id[ID_W*e +: ID_W]),
      .next_i    (eng_next_id[ID_W*e +: ID_W]),
      .pend_o    (pending[e]),
      .phase_o   (info_phase[2*e +: 2]),
      .prev_o    (info_prev_id[ID_W*e +: ID_W]),
      .next_o    (info_next_id[ID_W*e +: ID_W]),
      .status_o  (info_status[2*e +: 2])
    );
  end
endmodule

// File: rtl/ctxsw_watchdog_chk.sv
module ctxsw_watchdog_chk #(
  parameter int NUM_ENG = 8,
  parameter int ID_W    = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    det_en,
  input logic                    clr_we,
  input logic [NUM_ENG-1:0]      clr_mask,
  input logic [NUM_ENG-1:0]      pending,
  input logic [2*NUM_ENG-1:0]    info_phase,
  input logic [ID_W*NUM_ENG-1:0] info_prev_id,
  input logic [ID_W*NUM_ENG-1:0] info_next_id,
  input logic [2*NUM_ENG-1:0]    info_status
);
  for (genvar e = 0; e < NUM_ENG; e++) begin : g_chk
    logic clr_e;
    assign clr_e = clr_we && clr_mask[e];

    a_r2_no_detect: assert property (@(posedge clk) disable iff (rst)
      (!pending[e] && !det_en) |=> !pending[e]);

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !pending[e] |-> (info_status[2*e +: 2] == 2'd0 && info_phase[2*e +: 2] == 2'd0 &&
                       info_prev_id[ID_W*e +: ID_W] == '0 &&
                       info_next_id[ID_W*e +: ID_W] == '0));

    a_r4_snapshot_frozen: assert property (@(posedge clk) disable iff (rst)
      (pending[e] && !clr_e) |=> ($stable(info_phase[2*e +: 2]) &&
                                  $stable(info_prev_id[ID_W*e +: ID_W]) &&
                                  $stable(info_next_id[ID_W*e +: ID_W])));

    a_r5_starts_awaiting: assert property (@(posedge clk) disable iff (rst)
      $rose(pending[e]) |-> info_status[2*e +: 2] == 2'd0);

    a_r6_ack_no_regress: assert property (@(posedge clk) disable iff (rst)
      (pending[e] && !clr_e && info_status[2*e +: 2] == 2'd2) |=>
      (info_status[2*e +: 2] == 2'd2 || info_status[2*e +: 2] == 2'd3));

    a_r8_dropped_sticky: assert property (@(posedge clk) disable iff (rst)
      (pending[e] && !clr_e && info_status[2*e +: 2] == 2'd3) |=>
      (pending[e] && info_status[2*e +: 2] == 2'd3));
  end
endmodule

bind ctxsw_watchdog ctxsw_watchdog_chk #(.NUM_ENG(NUM_ENG), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .det_en      (det_en_q),
  .clr_we      (clr_we),
  .clr_mask    (clr_mask),
  .pending     (pending),
  .info_phase  (info_phase),
  .info_prev_id(info_prev_id),
  .info_next_id(info_next_id),
  .info_status (info_status)
);

// File: tb/tb_ctxsw_watchdog.sv
module tb_ctxsw_watchdog;
  localparam int NE = 2;
  localparam int PW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [PW-1:0] cfg_period = '0;
  logic cfg_detect_en = 1'b0;
  logic clr_we = 1'b0;
  logic [NE-1:0] clr_mask = '0;
  logic [NE-1:0] eng_req = '0, eng_ack = '0, eng_rst = '0;
  logic [2*NE-1:0] eng_phase = '0;
  logic [IW*NE-1:0] eng_prev_id = '0, eng_next_id = '0;
  logic [NE-1:0] pending;
  logic [2*NE-1:0] info_phase, info_status;
  logic [IW*NE-1:0] info_prev_id, info_next_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctxsw_watchdog #(.NUM_ENG(NE), .PERIOD_W(PW), .ID_W(IW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_period(cfg_period),
    .cfg_detect_en(cfg_detect_en), .clr_we(clr_we), .clr_mask(clr_mask),
    .eng_req(eng_req), .eng_ack(eng_ack), .eng_rst(eng_rst),
    .eng_phase(eng_phase), .eng_prev_id(eng_prev_id), .eng_next_id(eng_next_id),
    .pending(pending), .info_phase(info_phase), .info_prev_id(info_prev_id),
    .info_next_id(info_next_id), .info_status(info_status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int st(input int e);
    return int'(info_status[2*e +: 2]);
  endfunction

  task automatic set_cfg(input int p, input bit en);
    cfg_we = 1'b1; cfg_period = PW'(p); cfg_detect_en = en;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic clear(input logic [NE-1:0] m);
    clr_we = 1'b1; clr_mask = m;
    tick();
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic set_snap0(input int ph, input int pv, input int nx);
    eng_phase[1:0] = 2'(ph);
    eng_prev_id[IW-1:0] = IW'(pv);
    eng_next_id[IW-1:0] = IW'(nx);
  endtask

  task automatic pulse(input int which, input int e);
    if (which == 0) eng_req[e] = 1'b1;
    else if (which == 1) eng_ack[e] = 1'b1;
    else eng_rst[e] = 1'b1;
    tick();
    eng_req = '0; eng_ack = '0; eng_rst = '0;
  endtask

  // Request on engine 0 and wait long enough for a timeout with period p
  task automatic time_out0(input int p);
    pulse(0, 0);
    repeat (p + 1) tick();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;
    chk("R3 reset pending", int'(pending), 0);
    chk("R5 reset status", int'(info_status), 0);

    // R1 R4 R5 R6: sweep period against acknowledge delay
    for (int p = 0; p <= 5; p++) begin
      set_cfg(p, 1'b1);
      for (int d = 1; d <= p + 4; d++) begin
        bit to_exp;
        int ph, pv, nx;
        ph = (p + d) % 3; pv = d % 8; nx = (p * 3 + 1) % 8;
        to_exp = (d >= p + 2);
        set_snap0(ph, pv, nx);
        pulse(0, 0);
        for (int k = 1; k <= d + 1; k++) begin
          if (k == d) eng_ack[0] = 1'b1;
          tick();
          eng_ack[0] = 1'b0;
          chk($sformatf("R1 pending p=%0d d=%0d k=%0d", p, d, k), int'(pending[0]),
              int'(to_exp && k >= p + 1));
          if (to_exp && k >= p + 1)
            chk($sformatf("R6 status p=%0d d=%0d k=%0d", p, d, k), st(0), (k >= d) ? 2 : 0);
        end
        if (to_exp) begin
          set_snap0((ph + 1) % 3, pv ^ 7, nx ^ 5);
          tick();
          chk("R4 phase frozen", int'(info_phase[1:0]), ph);
          chk("R4 prev frozen", int'(info_prev_id[IW-1:0]), pv);
          chk("R4 next frozen", int'(info_next_id[IW-1:0]), nx);
          clear(2'b01);
          chk("R3 cleared pending", int'(pending[0]), 0);
          chk("R3 cleared fields", int'(info_phase[1:0]) + int'(info_prev_id[IW-1:0]) + st(0), 0);
        end
      end
    end

    // R2: detection disabled
    set_cfg(2, 1'b0);
    pulse(0, 0);
    repeat (12) tick();
    chk("R2 no pending when disabled", int'(pending), 0);
    pulse(1, 0);
    set_cfg(2, 1'b1);

    // R10: reload on new request
    set_cfg(4, 1'b1);
    pulse(0, 0);              // E0
    tick(); tick();           // E1, E2
    pulse(0, 0);              // E3 reload
    repeat (4) tick();        // E7
    chk("R10 reload delays timeout", int'(pending[0]), 0);
    tick();                   // E8
    chk("R10 timeout after reload", int'(pending[0]), 1);
    pulse(1, 0);
    clear(2'b01);
    // R10: engine reset stops the count
    pulse(0, 0);
    tick();
    pulse(2, 0);
    repeat (12) tick();
    chk("R10 reset stops count", int'(pending[0]), 0);

    // R7: engine reset then in-flight ack
    set_cfg(2, 1'b1);
    time_out0(2);
    chk("R7 timed out", st(0) + 4 * int'(pending[0]), 4);
    pulse(2, 0);
    chk("R7 status engine reset", st(0), 1);
    tick();
    chk("R7 status holds", st(0), 1);
    pulse(1, 0);
    chk("R7 in-flight ack", st(0), 2);
    clear(2'b01);

    // R8: dropped after ack
    set_snap0(1, 3, 4);
    time_out0(2);
    pulse(1, 0);
    chk("R8 acked first", st(0), 2);
    set_snap0(2, 6, 7);
    time_out0(2);
    chk("R8 dropped", st(0), 3);
    chk("R8 snapshot kept", int'(info_prev_id[IW-1:0]) * 8 + int'(info_next_id[IW-1:0]), 3 * 8 + 4);
    pulse(1, 0);
    time_out0(2);
    chk("R8 dropped sticky", st(0), 3);
    pulse(1, 0);
    clear(2'b01);
    // R8: dropped after engine reset
    time_out0(2);
    pulse(2, 0);
    time_out0(2);
    chk("R8 dropped after reset", st(0), 3);
    pulse(1, 0);
    clear(2'b01);

    // R9: save-phase timeout acked during load
    set_snap0(2, 5, 1);
    time_out0(2);
    set_snap0(0, 5, 1);
    pulse(1, 0);
    chk("R9 ack status", st(0), 2);
    chk("R9 phase still save", int'(info_phase[1:0]), 2);
    clear(2'b01);

    // R11: clear and new timeout in the same cycle
    set_snap0(1, 2, 2);
    time_out0(2);
    pulse(1, 0);
    set_snap0(2, 7, 6);
    pulse(0, 0);              // E0
    tick(); tick();           // E1, E2
    chk("R11 before second timeout", st(0), 2);
    clr_we = 1'b1; clr_mask = 2'b01;
    tick();                   // E3: timeout and clear
    clr_we = 1'b0; clr_mask = '0;
    chk("R11 pending kept", int'(pending[0]), 1);
    chk("R11 fresh status", st(0), 0);
    chk("R11 fresh snapshot", int'(info_prev_id[IW-1:0]) * 8 + int'(info_next_id[IW-1:0]), 7 * 8 + 6);
    pulse(1, 0);
    clear(2'b01);

    // R12 R3: two engines, partial and full clear
    eng_req = 2'b11;
    tick();
    eng_req = '0;
    repeat (3) tick();
    chk("R12 both pending", int'(pending), 3);
    pulse(1, 1);
    chk("R12 ack on one engine", st(1) * 4 + st(0), 2 * 4 + 0);
    clear(2'b01);
    chk("R3 partial clear", int'(pending), 2);
    chk("R12 other engine kept", st(1), 2);
    pulse(1, 0);
    clear(2'b11);
    chk("R3 clear all", int'(pending), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end
endmodule